// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface and brings the memory from reset to a usable state. It holds the clock-enable pin low while the clock settles, then raises it and plays a fixed series of commands: precharge-all, a DLL enable in the extended mode register, a DLL reset in the mode register, a second precharge-all, a configurable number of auto-refreshes, and a final mode register write that leaves the DLL alone. Between commands it drives NOP and counts the required gaps in clock cycles.

The settle time is given in microseconds and a clock frequency in MHz. The precharge, refresh, mode-register and DLL lock gaps are all cycle-count parameters. The burst length, CAS latency and burst type fields arrive on a configuration input. The block copies them into both mode register writes and forces only the DLL-reset bit. When the last gap has passed and the DLL has had its lock time, `init_done` rises and stays high until the next reset.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: While reset is asserted and for STABLE_US*CLK_MHZ cycles after reset is released (cycles 0 to S-1, with cycle 0 the first cycle out of reset), cke is low, the command pins {cs_n,ras_n,cas_n,we_n} are 4'b1111 (deselect), ba and addr are zero, and init_done is low.
- R2: In cycle S the block drives NOP (4'b0111) and cke goes high. cke then stays high until the next reset.
- R3: After cycle S the only non-NOP commands are, in this order: precharge-all (4'b0010), extended mode register set (4'b0000 with ba=1), mode register set (4'b0000 with ba=0), precharge-all, REF_COUNT auto-refreshes (4'b0001), and a mode register set. Each is driven for exactly one cycle.
- R4: The first precharge-all is issued in cycle S+1. Each later command follows the previous one by TRP_CYC cycles after a precharge-all, by TRFC_CYC cycles after an auto-refresh, and by MRD_CYC cycles after a mode register command. Every other cycle carries NOP.
- R5: Every precharge-all drives addr bit 10 high, all other addr bits low, and ba=0.
- R6: The extended mode register set drives ba=1 and addr=0. A low bit 0 enables the DLL.
- R7: The first mode register set drives ba=0 and addr equal to mode_cfg with bit 8 forced high (DLL reset).
- R8: The final mode register set drives ba=0 and addr equal to mode_cfg with bit 8 forced low.
- R9: init_done rises in cycle max(T_fin + MRD_CYC, T_dll + DLL_LOCK_CYC). T_fin is the cycle of the final mode register set and T_dll the cycle of the DLL-reset write. Once high, init_done stays high and only NOP is driven until reset.
- R10: Exactly REF_COUNT auto-refreshes are issued. REF_COUNT is at least 2.
- R11: A reset asserted partway through the sequence returns every output to its R1 state, and the whole sequence restarts from cycle 0 after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_cfg | input | ADDR_W | Base mode register fields; bit 8 is replaced by the block |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address; selects the mode register |
| addr | output | ADDR_W | Address lines; carry mode register contents |
| init_done | output | 1 | High once initialization is complete |

## Verification
The bench aims at the exact issue cycle of each command, counted from reset release. A timer off by one would shift every later command and fail a cycle check. The DLL lock time is set longer than the remaining command chain, so a design that raises init_done right after the final mode register gap would report done 15 cycles early. The first configuration word already has bit 8 set, so a design that ORs instead of forcing would send a DLL reset again on the final write. A reset during the refresh phase catches a design that resumes where it stopped or that leaves the lock timer armed.

// File: rtl/ddr_pwrup_pkg.sv
package ddr_pwrup_pkg;

   // command pins {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_DESEL = 4'b1111,
      CMD_NOP   = 4'b0111,
      CMD_PALL  = 4'b0010,
      CMD_REF   = 4'b0001,
      CMD_MODE  = 4'b0000
   } ddr_cmd_e;

   typedef enum logic [3:0] {
      ST_PWR,
      ST_CKE,
      ST_PALL1,
      ST_EMRS,
      ST_MRS_DLL,
      ST_PALL2,
      ST_REF,
      ST_MRS_FIN,
      ST_LOCK,
      ST_DONE
   } ddr_step_e;

   localparam int DLL_RST_BIT = 8;
   localparam int PALL_BIT    = 10;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ddr_pwrup_steptmr.sv
module ddr_pwrup_steptmr #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else          cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/ddr_pwrup_locktmr.sv
module ddr_pwrup_locktmr #(
   parameter int DLL_LOCK_CYC = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic lock_ok
);

   localparam int LW = (DLL_LOCK_CYC > 2) ? $clog2(DLL_LOCK_CYC) : 1;
   localparam logic [LW-1:0] LK_LAST = LW'(DLL_LOCK_CYC - 1);

   logic [LW-1:0] lk;
   logic          armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk    <= '0;
         armed <= 1'b0;
      end else if (arm) begin
         lk    <= LW'(1);
         armed <= 1'b1;
      end else if (armed && (lk != LK_LAST)) begin
         lk <= lk + 1'b1;
      end
   end

   // true in the cycle before lock time has fully elapsed, so the
   // sequencer's registered step reaches DONE exactly on time
   assign lock_ok = armed && (lk == LK_LAST);

endmodule

// File: rtl/ddr_pwrup_fsm.sv
module ddr_pwrup_fsm
   import ddr_pwrup_pkg::*;
#(
   parameter int STABLE_CYC = 50000,
   parameter int TRP_CYC    = 4,
   parameter int TRFC_CYC   = 18,
   parameter int MRD_CYC    = 2,
   parameter int REF_COUNT  = 2,
   parameter int CNT_W      = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      lock_ok,
   output ddr_step_e step,
   output logic      issue,
   output logic      dll_arm
);

   localparam int RW = $clog2(REF_COUNT + 1);
   localparam logic [RW-1:0] REF_LAST = RW'(REF_COUNT - 1);

   ddr_step_e      nxt;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] gap;
   logic [RW-1:0]  ref_idx, ref_nxt;
   logic           last;

   ddr_pwrup_steptmr #(.CNT_W(CNT_W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (last),
      .cnt   (cnt)
   );

   always_comb begin
      case (step)
         ST_PWR:                        gap = CNT_W'(STABLE_CYC);
         ST_PALL1, ST_PALL2:            gap = CNT_W'(TRP_CYC);
         ST_EMRS, ST_MRS_DLL, ST_MRS_FIN: gap = CNT_W'(MRD_CYC);
         ST_REF:                        gap = CNT_W'(TRFC_CYC);
         default:                       gap = CNT_W'(1);
      endcase
   end

   assign last = (cnt == gap - 1'b1);

   always_comb begin
      nxt     = step;
      ref_nxt = ref_idx;
      if (last) begin
         case (step)
            ST_PWR:     nxt = ST_CKE;
            ST_CKE:     nxt = ST_PALL1;
            ST_PALL1:   nxt = ST_EMRS;
            ST_EMRS:    nxt = ST_MRS_DLL;
            ST_MRS_DLL: nxt = ST_PALL2;
            ST_PALL2: begin
               nxt     = ST_REF;
               ref_nxt = '0;
            end
            ST_REF: begin
               if (ref_idx == REF_LAST) nxt = ST_MRS_FIN;
               else                     ref_nxt = ref_idx + 1'b1;
            end
            ST_MRS_FIN: nxt = lock_ok ? ST_DONE : ST_LOCK;
            ST_LOCK:    if (lock_ok) nxt = ST_DONE;
            default:    nxt = ST_DONE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step    <= ST_PWR;
         ref_idx <= '0;
      end else begin
         step    <= nxt;
         ref_idx <= ref_nxt;
      end
   end

   always_comb begin
      case (step)
         ST_PALL1, ST_EMRS, ST_MRS_DLL, ST_PALL2, ST_REF, ST_MRS_FIN:
            issue = (cnt == '0);
         default:
            issue = 1'b0;
      endcase
   end

   assign dll_arm = issue && (step == ST_MRS_DLL);

endmodule

// File: rtl/ddr_pwrup_cmdenc.sv
module ddr_pwrup_cmdenc
   import ddr_pwrup_pkg::*;
#(
   parameter int ADDR_W  = 13,
   parameter int BA_W    = 2,
   parameter bit REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ddr_step_e         step,
   input  logic              issue,
   input  logic [ADDR_W-1:0] mode_cfg,
   output logic              cke,
   output logic [3:0]        cmd,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr,
   output logic              done
);

   logic              cke_c, done_c;
   logic [3:0]        cmd_c;
   logic [BA_W-1:0]   ba_c;
   logic [ADDR_W-1:0] addr_c;

   always_comb begin
      cke_c  = (step != ST_PWR);
      done_c = (step == ST_DONE);
      cmd_c  = (step == ST_PWR) ? CMD_DESEL : CMD_NOP;
      ba_c   = '0;
      addr_c = '0;
      if (issue) begin
         case (step)
            ST_PALL1, ST_PALL2: begin
               cmd_c            = CMD_PALL;
               addr_c[PALL_BIT] = 1'b1;
            end
            ST_EMRS: begin
               cmd_c = CMD_MODE;
               ba_c  = BA_W'(1);
            end
            ST_MRS_DLL: begin
               cmd_c               = CMD_MODE;
               addr_c              = mode_cfg;
               addr_c[DLL_RST_BIT] = 1'b1;
            end
            ST_MRS_FIN: begin
               cmd_c               = CMD_MODE;
               addr_c              = mode_cfg;
               addr_c[DLL_RST_BIT] = 1'b0;
            end
            ST_REF:  cmd_c = CMD_REF;
            default: cmd_c = CMD_NOP;
         endcase
      end
   end

   generate
      if (REG_OUT) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cke  <= 1'b0;
               cmd  <= CMD_DESEL;
               ba   <= '0;
               addr <= '0;
               done <= 1'b0;
            end else begin
               cke  <= cke_c;
               cmd  <= cmd_c;
               ba   <= ba_c;
               addr <= addr_c;
               done <= done_c;
            end
         end
      end else begin : g_comb
         assign cke  = cke_c;
         assign cmd  = cmd_c;
         assign ba   = ba_c;
         assign addr = addr_c;
         assign done = done_c;
      end
   endgenerate

endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
   import ddr_pwrup_pkg::*;
#(
   parameter int CLK_MHZ      = 250,
   parameter int STABLE_US    = 200,
   parameter int TRP_CYC      = 4,
   parameter int TRFC_CYC     = 18,
   parameter int MRD_CYC      = 2,
   parameter int DLL_LOCK_CYC = 200,
   parameter int REF_COUNT    = 2,
   parameter int ADDR_W       = 13,
   parameter int BA_W         = 2,
   parameter bit REG_OUT      = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] mode_cfg,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr,
   output logic              init_done
);

   localparam int STABLE_CYC = CLK_MHZ * STABLE_US;
   localparam int MAX_GAP    = imax(imax(STABLE_CYC, TRP_CYC), imax(TRFC_CYC, MRD_CYC));
   localparam int CNT_W      = $clog2(MAX_GAP + 1);

   generate
      if (STABLE_CYC < 1)    begin : g_bad_stable $error("settle time must be at least one cycle"); end
      if (TRP_CYC < 2)       begin : g_bad_trp    $error("TRP_CYC must be at least 2"); end
      if (TRFC_CYC < 2)      begin : g_bad_trfc   $error("TRFC_CYC must be at least 2"); end
      if (MRD_CYC < 2)       begin : g_bad_mrd    $error("MRD_CYC must be at least 2"); end
      if (DLL_LOCK_CYC < 2)  begin : g_bad_lock   $error("DLL_LOCK_CYC must be at least 2"); end
      if (REF_COUNT < 2)     begin : g_bad_ref    $error("REF_COUNT must be at least 2"); end
      if (ADDR_W < 11)       begin : g_bad_addr   $error("ADDR_W must cover bit 10"); end
      if (BA_W < 1)          begin : g_bad_ba     $error("BA_W must be at least 1"); end
   endgenerate

   ddr_step_e  step;
   logic       issue, dll_arm, lock_ok;
   logic [3:0] cmd;

   ddr_pwrup_fsm #(
      .STABLE_CYC (STABLE_CYC),
      .TRP_CYC    (TRP_CYC),
      .TRFC_CYC   (TRFC_CYC),
      .MRD_CYC    (MRD_CYC),
      .REF_COUNT  (REF_COUNT),
      .CNT_W      (CNT_W)
   ) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .lock_ok (lock_ok),
      .step    (step),
      .issue   (issue),
      .dll_arm (dll_arm)
   );

   ddr_pwrup_locktmr #(.DLL_LOCK_CYC(DLL_LOCK_CYC)) u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (dll_arm),
      .lock_ok (lock_ok)
   );

   ddr_pwrup_cmdenc #(
      .ADDR_W  (ADDR_W),
      .BA_W    (BA_W),
      .REG_OUT (REG_OUT)
   ) u_enc (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .issue    (issue),
      .mode_cfg (mode_cfg),
      .cke      (cke),
      .cmd      (cmd),
      .ba       (ba),
      .addr     (addr),
      .done     (init_done)
   );

   assign {cs_n, ras_n, cas_n, we_n} = cmd;

endmodule

// File: rtl/ddr_pwrup_seq_chk.sv
module ddr_pwrup_seq_chk #(
   parameter int ADDR_W       = 13,
   parameter int BA_W         = 2,
   parameter int DLL_LOCK_CYC = 200
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cke,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [BA_W-1:0]   ba,
   input logic [ADDR_W-1:0] addr,
   input logic              init_done
);

   localparam int KW = $clog2(DLL_LOCK_CYC + 1);

   logic [3:0] cmd;
   logic       is_mode, is_mrs, is_pall, is_ref, is_nop;
   logic [1:0] mrs_seen;
   logic       lk_armed;
   logic [KW-1:0] lk_cnt;

   assign cmd     = {cs_n, ras_n, cas_n, we_n};
   assign is_mode = (cmd == 4'b0000);
   assign is_mrs  = is_mode && (ba == '0);
   assign is_pall = (cmd == 4'b0010);
   assign is_ref  = (cmd == 4'b0001);
   assign is_nop  = (cmd == 4'b0111);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mrs_seen <= '0;
         lk_armed <= 1'b0;
         lk_cnt   <= '0;
      end else begin
         if (is_mrs && mrs_seen != 2'd3) mrs_seen <= mrs_seen + 1'b1;
         if (is_mrs && mrs_seen == 2'd0) begin
            lk_armed <= 1'b1;
            lk_cnt   <= KW'(1);
         end else if (lk_armed && lk_cnt != KW'(DLL_LOCK_CYC)) begin
            lk_cnt <= lk_cnt + 1'b1;
         end
      end
   end

   a_r1_desel_while_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> (cs_n && !init_done));

   a_r2_cke_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
      cke |=> cke);

   a_r4_mode_gap: assert property (@(posedge clk) disable iff (!rst_n)
      is_mode |=> is_nop);

   a_r4_pall_gap: assert property (@(posedge clk) disable iff (!rst_n)
      is_pall |=> is_nop);

   a_r4_ref_gap: assert property (@(posedge clk) disable iff (!rst_n)
      is_ref |=> is_nop);

   a_r5_pall_a10: assert property (@(posedge clk) disable iff (!rst_n)
      is_pall |-> addr[10]);

   a_r7_first_mrs_dll_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mrs && mrs_seen == 2'd0) |-> addr[8]);

   a_r8_final_mrs_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mrs && mrs_seen != 2'd0) |-> !addr[8]);

   a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   a_r9_done_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (lk_armed && lk_cnt == KW'(DLL_LOCK_CYC) && mrs_seen == 2'd2));

   a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> is_nop);

endmodule

bind ddr_pwrup_seq ddr_pwrup_seq_chk #(
   .ADDR_W       (ADDR_W),
   .BA_W         (BA_W),
   .DLL_LOCK_CYC (DLL_LOCK_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cke       (cke),
   .cs_n      (cs_n),
   .ras_n     (ras_n),
   .cas_n     (cas_n),
   .we_n      (we_n),
   .ba        (ba),
   .addr      (addr),
   .init_done (init_done)
);

// File: tb/ddr_pwrup_seq_bench.sv
`timescale 1ns/1ps
module ddr_pwrup_seq_bench;

   localparam int MHZ  = 250;
   localparam int US   = 1;
   localparam int S    = MHZ * US;
   localparam int TRP  = 3;
   localparam int TRFC = 6;
   localparam int MRD  = 2;
   localparam int LOCK = 40;
   localparam int NREF = 3;

   localparam int T_PALL1 = S + 1;
   localparam int T_EMRS  = T_PALL1 + TRP;
   localparam int T_MRS1  = T_EMRS + MRD;
   localparam int T_PALL2 = T_MRS1 + MRD;
   localparam int T_REF0  = T_PALL2 + TRP;
   localparam int T_MRS2  = T_REF0 + NREF * TRFC;
   localparam int T_DONE  = ((T_MRS2 + MRD) > (T_MRS1 + LOCK)) ? (T_MRS2 + MRD) : (T_MRS1 + LOCK);

   localparam logic [12:0] CFG_A = 13'h0132;
   localparam logic [12:0] CFG_B = 13'h00A5;

   localparam int NEV = 9;
   localparam int EV_CYC [NEV] = '{S, T_PALL1, T_EMRS, T_MRS1, T_PALL2,
                                   T_REF0, T_REF0 + TRFC, T_REF0 + 2*TRFC, T_MRS2};
   localparam logic [3:0] EV_CMD [NEV] = '{4'b0111, 4'b0010, 4'b0000, 4'b0000, 4'b0010,
                                           4'b0001, 4'b0001, 4'b0001, 4'b0000};
   localparam logic [1:0] EV_BA [NEV] = '{2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0};
   localparam logic [12:0] EV_ADR [NEV] = '{13'h0, 13'h400, 13'h0, CFG_A | 13'h100, 13'h400,
                                            13'h0, 13'h0, 13'h0, CFG_A & ~13'h100};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] mode_cfg = CFG_A;
   logic        cke, cs_n, ras_n, cas_n, we_n, init_done;
   logic [1:0]  ba;
   logic [12:0] addr;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit fin = 1'b0;

   always #2 clk = ~clk;

   ddr_pwrup_seq #(
      .CLK_MHZ(MHZ), .STABLE_US(US), .TRP_CYC(TRP), .TRFC_CYC(TRFC),
      .MRD_CYC(MRD), .DLL_LOCK_CYC(LOCK), .REF_COUNT(NREF)
   ) u_ddr_pwrup_seq (
      .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .cke(cke),
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .ba(ba), .addr(addr), .init_done(init_done)
   );

   function automatic string ev_tag(input int i);
      case (i)
         0:       return "R2";
         1, 4:    return "R5";
         2:       return "R6";
         3:       return "R7";
         8:       return "R8";
         default: return "R10";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s cycle=%0d actual=%h expected=%h", tag, cyc, act, exp);
      end
   endtask

   task automatic release_rst();
      @(negedge clk);
      rst_n = 1'b1;
      cyc = 0;
      #0.5;
   endtask

   task automatic step1();
      @(posedge clk);
      @(negedge clk);
      cyc++;
   endtask

   task automatic run_to(input int c);
      while (cyc < c) step1();
   endtask

   task automatic chk_reset_state(input string tag);
      chk(tag, {31'd0, cke}, 32'd0);
      chk(tag, {28'd0, cs_n, ras_n, cas_n, we_n}, 32'hF);
      chk(tag, {17'd0, ba, addr}, 32'd0);
      chk(tag, {31'd0, init_done}, 32'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!fin) begin
         total++;
         bad++;
         $display("FAIL R9 watchdog actual=unfinished expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int nref;
      // R1: outputs while reset is held
      repeat (3) @(negedge clk);
      chk_reset_state("R1");

      // table walk: every cycle of the sequence against the event list
      release_rst();
      nref = 0;
      for (int c = 0; c <= T_DONE + 4; c++) begin
         logic [3:0]  ecmd;
         logic [1:0]  eba;
         logic [12:0] eadr;
         string       tag;
         run_to(c);
         ecmd = (c < S) ? 4'b1111 : 4'b0111;
         eba  = '0;
         eadr = '0;
         tag  = (c < S) ? "R1" : ((c >= T_DONE) ? "R9" : "R4");
         for (int i = 0; i < NEV; i++) begin
            if (EV_CYC[i] == c) begin
               ecmd = EV_CMD[i];
               eba  = EV_BA[i];
               eadr = EV_ADR[i];
               tag  = ev_tag(i);
            end
         end
         if ({cs_n, ras_n, cas_n, we_n} == 4'b0001) nref++;
         chk(tag == "R1" ? "R1" : (c > S ? "R3" : tag), {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, ecmd});
         if (ecmd != 4'b0111 && ecmd != 4'b1111) chk(tag, {17'd0, ba, addr}, {17'd0, eba, eadr});
         chk("R2", {31'd0, cke}, {31'd0, (c >= S)});
         chk("R9", {31'd0, init_done}, {31'd0, (c >= T_DONE)});
      end
      chk("R10", nref, NREF);

      // R9: done stays high and the bus stays quiet long after
      for (int k = 0; k < 10; k++) begin
         repeat (50) step1();
         chk("R9", {27'd0, init_done, cs_n, ras_n, cas_n, we_n}, {27'd0, 1'b1, 4'b0111});
      end

      // R11: restart in the middle of the refresh phase
      rst_n = 1'b0;
      run_to(0);
      release_rst();
      run_to(T_REF0 + 2);
      @(negedge clk);
      rst_n = 1'b0;
      mode_cfg = CFG_B;
      #0.5;
      chk_reset_state("R11");
      release_rst();
      chk("R11", {31'd0, cke}, 32'd0);
      run_to(S - 1);
      chk("R11", {28'd0, cs_n, ras_n, cas_n, we_n}, 32'hF);
      run_to(S);
      chk("R11", {31'd0, cke}, 32'd1);
      run_to(T_MRS1);
      chk("R7", {17'd0, cs_n, ras_n, cas_n, we_n, ba, addr[10:0]},
                {17'd0, 4'b0000, 2'd0, 11'((CFG_B | 13'h100) & 13'h7FF)});
      chk("R7", {19'd0, addr}, {19'd0, CFG_B | 13'h100});
      run_to(T_MRS2);
      chk("R8", {19'd0, addr}, {19'd0, CFG_B & ~13'h100});
      chk("R8", {28'd0, cs_n, ras_n, cas_n, we_n}, 32'd0);
      run_to(T_DONE - 1);
      chk("R9", {31'd0, init_done}, 32'd0);
      run_to(T_DONE);
      chk("R9", {31'd0, init_done}, 32'd1);

      fin = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule